// File: doc/BRIEF.md
# Bundle Snooping Pipeline Stage

This stage sits in-line on a stream of pipeline bundles. A beat is a 9-bit type code and a 32-bit data word, moved by a valid/ready handshake on each side. Most types mean nothing to the stage and go through untouched and in order. A few types are state bundles. When one of these passes, its data word is copied into one of the stage's configuration registers. These are four scalar slots plus a 16-entry array that sits at a run of consecutive codes. Two further types are triggers. One clears an internal event counter, and the other copies that counter into a readable register. Each trigger also raises a single-cycle pulse.

For each state slot, and for the array as a whole, a consume-enable bit decides what happens after the stage has stored the bundle. With the bit clear, the bundle is also forwarded. With the bit set, the stage swallows it, because no later stage needs it. A software port reads and writes every stored copy, so the state can be saved and later restored across a context switch.

Top module: `bundle_tap_stage`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, every state slot and array entry reads 0, `sampled_count` is 0 and both trigger pulses are 0.
- R2: A bundle whose type is not recognised leaves on `out_type`/`out_data` unchanged, with `out_valid` high in the cycle after it is accepted. Bundles leave in arrival order.
- R3: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output beat stays stable. No bundle is lost or duplicated.
- R4: Types 0x053, 0x054, 0x055 and 0x082 load scalar slots 0, 1, 2 and 3. The new value reads back at software address 0 to 3 from the cycle after acceptance.
- R5: Type 0x100+i, for i from 0 to 15, loads array entry i, which reads back at software address 16+i. Type 0x110 is not an array type and passes through.
- R6: `consume_en` bit k (k = 0..3) belongs to scalar slot k, and bit 4 belongs to the whole array. With the bit set, the bundle updates state and is not forwarded. With the bit clear, it updates state and is forwarded.
- R7: Type 0x1fd zeroes the event counter and raises `trig_clear_pulse` for exactly one cycle, the cycle after acceptance. The bundle is forwarded.
- R8: Type 0x1fc loads `sampled_count` with the counter value held at acceptance and raises `trig_sample_pulse` for exactly one cycle. The bundle is forwarded.
- R9: The counter adds one on each clock where `evt_tick` is high. A clear in the same cycle wins over the tick.
- R10: `sw_rdata` shows the addressed copy combinationally. `sw_wr_en` writes `sw_wdata` into it at the clock, and this write takes priority over a bundle that hits the same slot in the same cycle.
- R11: Software addresses 4 to 15 name no register. They read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| consume_en | input | 5 | Per-slot consume enables, bit 4 for the array |
| evt_tick | input | 1 | Event counter increment |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage can accept a beat |
| in_type | input | 9 | Input bundle type |
| in_data | input | 32 | Input bundle data |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts |
| out_type | output | 9 | Output bundle type |
| out_data | output | 32 | Output bundle data |
| sw_addr | input | 5 | Save/restore address |
| sw_wr_en | input | 1 | Restore write strobe |
| sw_wdata | input | 32 | Restore data |
| sw_rdata | output | 32 | Save read data |
| sampled_count | output | 16 | Counter value captured by the sample trigger |
| trig_clear_pulse | output | 1 | One-cycle pulse after a clear trigger |
| trig_sample_pulse | output | 1 | One-cycle pulse after a sample trigger |

## Verification
The bench targets the edges of the array window, 0x100 and 0x10f against 0x110. A decoder with an off-by-one would either drop a pass-through bundle or corrupt an entry. A stalled output is held for several cycles and then released while a second beat waits. A wrong ready equation would overwrite the held beat or emit it twice. A clear trigger arrives together with an event tick, and a later sample shows whether the clear won. The restore write collides with a bundle aimed at the same slot, and writes to the unused address range must read back as zero.

// File: rtl/bundle_tap_pkg.sv
package bundle_tap_pkg;

    typedef enum logic [2:0] {
        BK_PASS   = 3'd0,
        BK_STATE  = 3'd1,
        BK_ARRAY  = 3'd2,
        BK_CLEAR  = 3'd3,
        BK_SAMPLE = 3'd4
    } bundle_kind_e;

endpackage

// File: rtl/bundle_tap_decode.sv
module bundle_tap_decode
    import bundle_tap_pkg::*;
#(
    parameter int                          TYPE_W      = 9,
    parameter int                          NUM_SCALAR  = 4,
    parameter int                          ARR_DEPTH   = 16,
    parameter logic [NUM_SCALAR*TYPE_W-1:0] SCALAR_CODES = {9'h082, 9'h055, 9'h054, 9'h053},
    parameter logic [TYPE_W-1:0]           ARR_BASE    = 9'h100,
    parameter logic [TYPE_W-1:0]           TRIG_CLEAR  = 9'h1fd,
    parameter logic [TYPE_W-1:0]           TRIG_SAMPLE = 9'h1fc,
    localparam int                         IDX_W       = $clog2(ARR_DEPTH)
) (
    input  logic [TYPE_W-1:0]   in_type,
    input  logic [NUM_SCALAR:0] consume_en,
    output bundle_kind_e        kind,
    output logic [IDX_W-1:0]    slot_idx,
    output logic                consume
);

    logic [NUM_SCALAR-1:0] scalar_hit;
    logic [TYPE_W-1:0]     arr_off;

    for (genvar g = 0; g < NUM_SCALAR; g++) begin : g_match
        assign scalar_hit[g] = (in_type == SCALAR_CODES[g*TYPE_W +: TYPE_W]);
    end

    assign arr_off = in_type - ARR_BASE;

    always_comb begin
        kind     = BK_PASS;
        slot_idx = '0;
        consume  = 1'b0;
        if (in_type >= ARR_BASE && arr_off < TYPE_W'(ARR_DEPTH)) begin
            kind     = BK_ARRAY;
            slot_idx = arr_off[IDX_W-1:0];
            consume  = consume_en[NUM_SCALAR];
        end else if (in_type == TRIG_CLEAR) begin
            kind = BK_CLEAR;
        end else if (in_type == TRIG_SAMPLE) begin
            kind = BK_SAMPLE;
        end else begin
            for (int k = 0; k < NUM_SCALAR; k++) begin
                if (scalar_hit[k]) begin
                    kind     = BK_STATE;
                    slot_idx = IDX_W'(k);
                    consume  = consume_en[k];
                end
            end
        end
    end

endmodule

// File: rtl/bundle_tap_bank.sv
module bundle_tap_bank #(
    parameter int  DATA_W     = 32,
    parameter int  NUM_SCALAR = 4,
    parameter int  ARR_DEPTH  = 16,
    localparam int IDX_W      = $clog2(ARR_DEPTH),
    localparam int SC_W       = $clog2(NUM_SCALAR),
    localparam int ADDR_W     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bnk_wr,
    input  logic              bnk_arr,
    input  logic [IDX_W-1:0]  bnk_idx,
    input  logic [DATA_W-1:0] bnk_data,
    input  logic              sw_wr,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata
);

    typedef struct packed {
        logic [NUM_SCALAR-1:0][DATA_W-1:0] scal;
        logic [ARR_DEPTH-1:0][DATA_W-1:0]  arr;
    } bank_t;

    bank_t bank_d, bank_q;

    logic             sw_is_arr;
    logic [IDX_W-1:0] sw_idx;
    logic             sw_scal_ok;

    assign sw_is_arr  = sw_addr[ADDR_W-1];
    assign sw_idx     = sw_addr[IDX_W-1:0];
    assign sw_scal_ok = (int'(sw_idx) < NUM_SCALAR);

    always_comb begin
        bank_d = bank_q;
        if (bnk_wr) begin
            if (bnk_arr) begin
                bank_d.arr[bnk_idx] = bnk_data;
            end else if (int'(bnk_idx) < NUM_SCALAR) begin
                bank_d.scal[bnk_idx[SC_W-1:0]] = bnk_data;
            end
        end
        if (sw_wr) begin
            if (sw_is_arr) begin
                bank_d.arr[sw_idx] = sw_wdata;
            end else if (sw_scal_ok) begin
                bank_d.scal[sw_idx[SC_W-1:0]] = sw_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        if (sw_is_arr)       sw_rdata = bank_q.arr[sw_idx];
        else if (sw_scal_ok) sw_rdata = bank_q.scal[sw_idx[SC_W-1:0]];
        else                 sw_rdata = '0;
    end

    // R4: a scalar bundle write lands in its slot
    a_r4_scalar_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bnk_wr && !bnk_arr && !sw_wr)
        |=> bank_q.scal[$past(bnk_idx[SC_W-1:0])] == $past(bnk_data));

    // R5: an array bundle write lands in its entry
    a_r5_array_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bnk_wr && bnk_arr && !sw_wr)
        |=> bank_q.arr[$past(bnk_idx)] == $past(bnk_data));

    // R10: a restore write to the array wins
    a_r10_restore_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_is_arr)
        |=> bank_q.arr[$past(sw_idx)] == $past(sw_wdata));

endmodule

// File: rtl/bundle_tap_events.sv
module bundle_tap_events #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             do_clear,
    input  logic             do_sample,
    output logic [CNT_W-1:0] sampled,
    output logic             pulse_clear,
    output logic             pulse_sample
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] smp;
        logic             p_clr;
        logic             p_smp;
    } ev_t;

    ev_t ev_d, ev_q;

    always_comb begin
        ev_d       = ev_q;
        ev_d.p_clr = do_clear;
        ev_d.p_smp = do_sample;
        if (do_clear)  ev_d.cnt = '0;
        else if (tick) ev_d.cnt = ev_q.cnt + 1'b1;
        if (do_sample) ev_d.smp = ev_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign sampled      = ev_q.smp;
    assign pulse_clear  = ev_q.p_clr;
    assign pulse_sample = ev_q.p_smp;

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q.p_clr |-> ev_q.cnt == '0);

    a_r8_sample_value: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q.p_smp |-> ev_q.smp == $past(ev_q.cnt));

    a_r9_tick_count: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !do_clear) |=> ev_q.cnt == $past(ev_q.cnt) + 1'b1);

endmodule

// File: rtl/bundle_tap_stage.sv
module bundle_tap_stage
    import bundle_tap_pkg::*;
#(
    parameter int  TYPE_W     = 9,
    parameter int  DATA_W     = 32,
    parameter int  NUM_SCALAR = 4,
    parameter int  ARR_DEPTH  = 16,
    parameter int  CNT_W      = 16,
    localparam int IDX_W      = $clog2(ARR_DEPTH),
    localparam int ADDR_W     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SCALAR:0] consume_en,
    input  logic              evt_tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TYPE_W-1:0] in_type,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TYPE_W-1:0] out_type,
    output logic [DATA_W-1:0] out_data,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic              sw_wr_en,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata,
    output logic [CNT_W-1:0]  sampled_count,
    output logic              trig_clear_pulse,
    output logic              trig_sample_pulse
);

    typedef struct packed {
        logic              vld;
        logic [TYPE_W-1:0] typ;
        logic [DATA_W-1:0] dat;
    } beat_t;

    beat_t        out_d, out_q;
    bundle_kind_e kind;
    logic [IDX_W-1:0] slot_idx;
    logic         consume;
    logic         accept;
    logic         fwd;

    bundle_tap_decode #(
        .TYPE_W     (TYPE_W),
        .NUM_SCALAR (NUM_SCALAR),
        .ARR_DEPTH  (ARR_DEPTH)
    ) i_decode (
        .in_type    (in_type),
        .consume_en (consume_en),
        .kind       (kind),
        .slot_idx   (slot_idx),
        .consume    (consume)
    );

    assign in_ready = !out_q.vld || out_ready;
    assign accept   = in_valid && in_ready;
    assign fwd      = accept && !consume;

    always_comb begin
        out_d = out_q;
        if (out_ready) out_d.vld = 1'b0;
        if (fwd) begin
            out_d.vld = 1'b1;
            out_d.typ = in_type;
            out_d.dat = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign out_type  = out_q.typ;
    assign out_data  = out_q.dat;

    bundle_tap_bank #(
        .DATA_W     (DATA_W),
        .NUM_SCALAR (NUM_SCALAR),
        .ARR_DEPTH  (ARR_DEPTH)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .bnk_wr   (accept && (kind == BK_STATE || kind == BK_ARRAY)),
        .bnk_arr  (kind == BK_ARRAY),
        .bnk_idx  (slot_idx),
        .bnk_data (in_data),
        .sw_wr    (sw_wr_en),
        .sw_addr  (sw_addr),
        .sw_wdata (sw_wdata),
        .sw_rdata (sw_rdata)
    );

    bundle_tap_events #(
        .CNT_W (CNT_W)
    ) i_events (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (evt_tick),
        .do_clear     (accept && kind == BK_CLEAR),
        .do_sample    (accept && kind == BK_SAMPLE),
        .sampled      (sampled_count),
        .pulse_clear  (trig_clear_pulse),
        .pulse_sample (trig_sample_pulse)
    );

    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready)
        |=> out_valid && $stable(out_type) && $stable(out_data));

    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && kind == BK_PASS)
        |=> out_valid && out_type == $past(in_type) && out_data == $past(in_data));

    a_r6_consumed_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && consume) |=> !out_valid);

endmodule

// File: tb/test_bundle_tap_stage.sv
module test_bundle_tap_stage;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {expect forwarded, type, data}, run with consume_en = 5'b10001
    localparam logic [41:0] VEC [NVEC] = '{
        {1'b1, 9'h001, 32'h1111_1111},
        {1'b0, 9'h053, 32'hA0A0_0001},
        {1'b1, 9'h054, 32'hB0B0_0002},
        {1'b0, 9'h100, 32'hC000_0000},
        {1'b0, 9'h10F, 32'hC000_000F},
        {1'b1, 9'h110, 32'hD000_0010},
        {1'b1, 9'h0FF, 32'hE0E0_00FF},
        {1'b1, 9'h082, 32'hF0F0_0082}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  consume_en = '0;
    logic        evt_tick = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [8:0]  in_type = '0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [8:0]  out_type;
    logic [31:0] out_data;
    logic [4:0]  sw_addr = '0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic [15:0] sampled_count;
    logic        trig_clear_pulse;
    logic        trig_sample_pulse;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bundle_tap_stage i_bundle_tap_stage (
        .clk               (clk),
        .rst_n             (rst_n),
        .consume_en        (consume_en),
        .evt_tick          (evt_tick),
        .in_valid          (in_valid),
        .in_ready          (in_ready),
        .in_type           (in_type),
        .in_data           (in_data),
        .out_valid         (out_valid),
        .out_ready         (out_ready),
        .out_type          (out_type),
        .out_data          (out_data),
        .sw_addr           (sw_addr),
        .sw_wr_en          (sw_wr_en),
        .sw_wdata          (sw_wdata),
        .sw_rdata          (sw_rdata),
        .sampled_count     (sampled_count),
        .trig_clear_pulse  (trig_clear_pulse),
        .trig_sample_pulse (trig_sample_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        sw_addr = a;
        #1;
        chk(req, sw_rdata, exp);
    endtask

    // Presents one beat at a falling edge, waits for acceptance, returns
    // at the falling edge after the accepting clock.
    task automatic send(input logic [8:0] t, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_type  = t;
        in_data  = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        #1;
        // R1: reset state
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 in_ready", 32'(in_ready), 32'd1);
        chk("R1 sampled", 32'(sampled_count), 32'd0);
        chk("R1 pulses", {30'd0, trig_clear_pulse, trig_sample_pulse}, 32'd0);
        rd("R1 slot0", 5'd0, 32'd0);
        rd("R1 entry0", 5'd16, 32'd0);

        // R2 R4 R5 R6: vector table
        consume_en = 5'b10001;
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v][40:32], VEC[v][31:0]);
            chk("R6 forwarded", 32'(out_valid), 32'(VEC[v][41]));
            if (VEC[v][41]) begin
                chk("R2 type", 32'(out_type), 32'(VEC[v][40:32]));
                chk("R2 data", out_data, VEC[v][31:0]);
            end
        end
        rd("R4 slot0", 5'd0, 32'hA0A0_0001);
        rd("R4 slot1", 5'd1, 32'hB0B0_0002);
        rd("R4 slot2 untouched", 5'd2, 32'd0);
        rd("R4 slot3", 5'd3, 32'hF0F0_0082);
        rd("R5 entry0", 5'd16, 32'hC000_0000);
        rd("R5 entry15", 5'd31, 32'hC000_000F);
        rd("R5 entry1 untouched", 5'd17, 32'd0);

        // R6: forward when bit clear, consume per array bit
        consume_en = 5'b00000;
        send(9'h055, 32'h0000_0055);
        chk("R6 slot2 forwarded", {out_valid, 22'd0, out_type}, {1'b1, 22'd0, 9'h055});
        rd("R4 slot2", 5'd2, 32'h0000_0055);
        consume_en = 5'b10000;
        send(9'h105, 32'h0000_0105);
        chk("R6 array consumed", 32'(out_valid), 32'd0);
        rd("R5 entry5", 5'd21, 32'h0000_0105);
        consume_en = 5'b00000;

        // R3: backpressure
        out_ready = 1'b0;
        send(9'h001, 32'h0000_0001);
        chk("R3 first held", out_data, 32'h0000_0001);
        @(negedge clk);
        in_valid = 1'b1;
        in_type  = 9'h002;
        in_data  = 32'h0000_0002;
        #1;
        chk("R3 stalled ready", 32'(in_ready), 32'd0);
        repeat (3) @(negedge clk);
        chk("R3 stable data", out_data, 32'h0000_0001);
        chk("R3 stable valid", 32'(out_valid), 32'd1);
        out_ready = 1'b1;
        #1;
        chk("R3 ready on drain", 32'(in_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R3 second beat", {out_valid, 22'd0, out_type}, {1'b1, 22'd0, 9'h002});
        chk("R3 second data", out_data, 32'h0000_0002);
        @(negedge clk);
        chk("R3 no duplicate", 32'(out_valid), 32'd0);

        // R8 R9: count 5 ticks then sample
        evt_tick = 1'b1;
        repeat (5) @(negedge clk);
        evt_tick = 1'b0;
        send(9'h1fc, 32'd0);
        chk("R8 sampled", 32'(sampled_count), 32'd5);
        chk("R8 pulse", 32'(trig_sample_pulse), 32'd1);
        chk("R8 forwarded", 32'(out_type), 32'h1fc);
        @(negedge clk);
        chk("R8 pulse one cycle", 32'(trig_sample_pulse), 32'd0);

        // R7 R9: clear wins over a tick
        evt_tick = 1'b1;
        send(9'h1fd, 32'd0);
        evt_tick = 1'b0;
        chk("R7 pulse", 32'(trig_clear_pulse), 32'd1);
        chk("R7 forwarded", 32'(out_type), 32'h1fd);
        @(negedge clk);
        chk("R7 pulse one cycle", 32'(trig_clear_pulse), 32'd0);
        evt_tick = 1'b1;
        repeat (3) @(negedge clk);
        evt_tick = 1'b0;
        send(9'h1fc, 32'd0);
        chk("R9 clear beats tick", 32'(sampled_count), 32'd3);

        // R10: restore write beats a bundle to the same slot
        @(negedge clk);
        in_valid = 1'b1;
        in_type  = 9'h053;
        in_data  = 32'h0000_BBBB;
        sw_wr_en = 1'b1;
        sw_addr  = 5'd0;
        sw_wdata = 32'h0000_AAAA;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        sw_wr_en = 1'b0;
        rd("R10 priority", 5'd0, 32'h0000_AAAA);
        @(negedge clk);
        sw_wr_en = 1'b1;
        sw_addr  = 5'd20;
        sw_wdata = 32'h1234_5678;
        @(negedge clk);
        sw_wr_en = 1'b0;
        rd("R10 array restore", 5'd20, 32'h1234_5678);

        // R11: hole in the address map
        @(negedge clk);
        sw_wr_en = 1'b1;
        sw_addr  = 5'd5;
        sw_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        sw_wr_en = 1'b0;
        rd("R11 hole reads zero", 5'd5, 32'd0);
        rd("R11 slot1 intact", 5'd1, 32'hB0B0_0002);

        // R1: reset clears stored state
        do_reset();
        #1;
        rd("R1 slot3 after reset", 5'd3, 32'd0);
        rd("R1 entry15 after reset", 5'd31, 32'd0);
        chk("R1 sampled after reset", 32'(sampled_count), 32'd0);

        finish_run();
    end

endmodule